// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block models a small parallel NOR flash behind a single-cycle synchronous bus. The array is a byte memory split into equal sectors. A read returns data in the same cycle. A write is applied at the next rising clock edge. Each write carries a byte address, up to 32 bits of data, an access size of 1, 2 or 4 bytes, and a byte-order strap.

The low byte of every write is decoded by a command state machine that counts write cycles. The machine supports these operations:
- single-word program
- sector erase with a confirm cycle
- status clear
- lock setup with a confirm cycle
- status and identifier read modes
- a query mode
- buffered multi-word program, whose word count is taken from the data bus
- return to array reads

A read-only strap suppresses every change to the array and sets error bits in the status register. The current command selects what a read returns: array bytes, the status register, identifier bytes or query bytes.

A secure-only strap, together with a per-access non-secure flag, makes the block answer non-secure reads with raw array data. Non-secure writes are refused with an error flag.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset the block is in array-read mode at write cycle 0 with status 0x00, and every array byte reads 0xFF.
- R2: In array-read mode, a read with size code 0/1/2 (1/2/4 bytes; code 3 acts as 4) returns the bytes at addr, addr+1, and so on. With `big_end`=0, the byte at addr sits in bits 7:0. With `big_end`=1, it sits in the most significant used byte. Unused upper bits are zero.
- R3: Command 0x10 or 0x40 arms a program. The next write stores its data at its address with its size and byte order, sets status bit 7 and returns to cycle 0. Reads then return the status register. A status read replicates the 8-bit status into every byte of the access size.
- R4: When `read_only`=1, a program stores nothing and sets status bits 7 and 4.
- R5: Command 0x20 fills with 0xFF the whole sector that holds the address (addr with its low log2(SECT_BYTES) bits cleared) and sets status bit 7. When `read_only`=1, nothing is erased and bits 7 and 5 are set. Other sectors are untouched.
- R6: In the cycle after 0x20, a write of 0xD0 sets bit 7 and ends the sequence in status mode. 0xFF returns to array mode. Any other value is an error that also returns to array mode.
- R7: Command 0x50 clears the status register to 0x00 and returns to array mode. Without it, no status bit that is set ever clears.
- R8: Commands 0x70 (status read) and 0x90 (identifier read) change the read source at once and leave the write cycle at 0, so the next write is decoded as a new command.
- R9: In identifier mode, address 0 reads ID_MFR, address 1 reads ID_DEV, and any other address reads 0. The value sits in the low byte.
- R10: After 0x60, a write of 0xD0 or 0x01 sets bit 7 and ends the sequence in status mode. Any other value returns to array mode.
- R11: Command 0xE8 sets bit 7. The next write supplies the count N in its low CNT_W bits. The following N+1 writes each store one word and set bit 7. A final 0xD0 sets bit 7 and returns to cycle 0 in status mode. Any other final value returns to array mode.
- R12: Command 0x98 enters query mode, where the low byte reads 0x51, 0x52, 0x59 at addresses 0x10, 0x11, 0x12. A write of 0xFF leaves for array mode; any other write keeps query mode.
- R13: An unsupported command byte in cycle 0 returns to array mode with cycle 0 and command cleared.
- R14: With `secure_only`=1 and `nonsec`=1, reads return array data whatever the mode. Writes raise `err` in their cycle and change neither the array nor the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req | input | 1 | Access valid this cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data; low byte is the command |
| size | input | 2 | Access size code: 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| big_end | input | 1 | Byte-order strap |
| read_only | input | 1 | Array write protection strap |
| secure_only | input | 1 | Restrict writes to secure accesses |
| nonsec | input | 1 | Access is non-secure |
| rdata | output | 32 | Read data, combinational in the access cycle |
| err | output | 1 | Write refused, combinational in the access cycle |

## Verification
Read data and `err` are combinational, so the bench samples them one nanosecond after driving an access on the falling edge. That point is well before the rising edge that would register anything. Every write takes effect at the first rising edge after it is driven, and `req` is dropped just after that edge. A read issued on the next falling edge therefore already sees the new array contents, status and mode, with no added delay. Each expected value comes from a byte-array model in the bench, updated by the same requirement rules.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int SECT_BYTES = 16,
  parameter int SECTS      = 4,
  parameter int CNT_W      = 8,
  parameter logic [7:0] ID_MFR = 8'h89,
  parameter logic [7:0] ID_DEV = 8'h18,
  localparam int DEPTH = SECT_BYTES * SECTS,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = $clog2(SECT_BYTES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic [1:0]    size,
  input  logic          big_end,
  input  logic          read_only,
  input  logic          secure_only,
  input  logic          nonsec,
  output logic [31:0]   rdata,
  output logic          err
);

  logic [7:0]       mem [DEPTH];
  logic [7:0]       cmd_q, nx_cmd;
  logic [1:0]       cyc_q, nx_cyc;
  logic [7:0]       stat_q, nx_stat;
  logic [CNT_W-1:0] cnt_q, nx_cnt;
  logic             do_store, do_erase;
  logic [2:0]       nb;
  logic [7:0]       rb [4];
  logic [7:0]       wb [4];
  logic [31:0]      arr_word, stat_word, qry_word, id_word;

  wire rej = secure_only & nonsec;
  wire [7:0] cb = wdata[7:0];
  wire wr_ok = req & we & ~rej;

  assign err = req & we & rej;
  assign nb  = (size == 2'd0) ? 3'd1 : (size == 2'd1) ? 3'd2 : 3'd4;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      rb[i] = mem[addr + AW'(i)];
      if (big_end)
        wb[i] = wdata[8*(32'(nb) - 1 - i) +: 8];
      else
        wb[i] = wdata[8*i +: 8];
    end
  end

  always_comb begin
    if (nb == 3'd1)      arr_word = {24'h0, rb[0]};
    else if (nb == 3'd2) arr_word = big_end ? {16'h0, rb[0], rb[1]} : {16'h0, rb[1], rb[0]};
    else                 arr_word = big_end ? {rb[0], rb[1], rb[2], rb[3]} : {rb[3], rb[2], rb[1], rb[0]};
  end

  assign stat_word = (nb == 3'd1) ? {24'h0, stat_q} :
                     (nb == 3'd2) ? {16'h0, stat_q, stat_q} : {4{stat_q}};

  assign id_word = (addr == AW'(0)) ? {24'h0, ID_MFR} :
                   (addr == AW'(1)) ? {24'h0, ID_DEV} : 32'h0;

  always_comb begin
    case (addr)
      AW'(8'h10): qry_word = 32'h51;
      AW'(8'h11): qry_word = 32'h52;
      AW'(8'h12): qry_word = 32'h59;
      AW'(8'h13): qry_word = 32'h01;
      AW'(8'h27): qry_word = 32'(AW);
      AW'(8'h2C): qry_word = 32'h01;
      AW'(8'h2D): qry_word = 32'(SECTS - 1);
      default:    qry_word = 32'h0;
    endcase
  end

  always_comb begin
    if (rej) rdata = arr_word;
    else begin
      case (cmd_q)
        8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8: rdata = stat_word;
        8'h90:   rdata = id_word;
        8'h98:   rdata = qry_word;
        default: rdata = arr_word;
      endcase
    end
  end

  always_comb begin
    nx_cmd = cmd_q;
    nx_cyc = cyc_q;
    nx_stat = stat_q;
    nx_cnt = cnt_q;
    do_store = 1'b0;
    do_erase = 1'b0;
    if (wr_ok) begin
      case (cyc_q)
        2'd0: begin
          case (cb)
            8'h00, 8'hF0, 8'hFF: nx_cmd = 8'h00;
            8'h50: begin nx_stat = 8'h00; nx_cmd = 8'h00; end
            8'h70, 8'h90: nx_cmd = cb;
            8'h10, 8'h40, 8'h60, 8'h98: begin nx_cmd = cb; nx_cyc = 2'd1; end
            8'h20: begin
              nx_cmd = cb;
              nx_cyc = 2'd1;
              nx_stat = stat_q | (read_only ? 8'hA0 : 8'h80);
              do_erase = ~read_only;
            end
            8'hE8: begin nx_cmd = cb; nx_cyc = 2'd1; nx_stat = stat_q | 8'h80; end
            default: nx_cmd = 8'h00;
          endcase
        end
        2'd1: begin
          case (cmd_q)
            8'h10, 8'h40: begin
              do_store = ~read_only;
              nx_stat = stat_q | (read_only ? 8'h90 : 8'h80);
              nx_cyc = 2'd0;
            end
            8'h20, 8'h60: begin
              nx_cyc = 2'd0;
              if (cb == 8'hD0 || (cmd_q == 8'h60 && cb == 8'h01))
                nx_stat = stat_q | 8'h80;
              else
                nx_cmd = 8'h00;
            end
            8'h98: if (cb == 8'hFF) begin nx_cmd = 8'h00; nx_cyc = 2'd0; end
            8'hE8: begin nx_cnt = wdata[CNT_W-1:0]; nx_cyc = 2'd2; end
            default: begin nx_cmd = 8'h00; nx_cyc = 2'd0; end
          endcase
        end
        2'd2: begin
          if (cmd_q == 8'hE8) begin
            do_store = ~read_only;
            nx_stat = stat_q | (read_only ? 8'h90 : 8'h80);
            if (cnt_q == '0) nx_cyc = 2'd3;
            nx_cnt = cnt_q - 1'b1;
          end else begin
            nx_cmd = 8'h00;
            nx_cyc = 2'd0;
          end
        end
        default: begin
          nx_cyc = 2'd0;
          if (cmd_q == 8'hE8 && cb == 8'hD0) nx_stat = stat_q | 8'h80;
          else nx_cmd = 8'h00;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= 8'h00;
      cyc_q <= 2'd0;
      stat_q <= 8'h00;
      cnt_q <= '0;
    end else begin
      cmd_q <= nx_cmd;
      cyc_q <= nx_cyc;
      stat_q <= nx_stat;
      cnt_q <= nx_cnt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int j = 0; j < DEPTH; j++) mem[j] <= 8'hFF;
    end else begin
      if (do_erase)
        for (int j = 0; j < DEPTH; j++)
          if ((AW'(j) >> SW) == (addr >> SW)) mem[j] <= 8'hFF;
      if (do_store)
        for (int i = 0; i < 4; i++)
          if (i < 32'(nb)) mem[addr + AW'(i)] <= wb[i];
    end
  end

endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req,
  input logic        we,
  input logic [31:0] wdata,
  input logic        secure_only,
  input logic        nonsec,
  input logic [7:0]  cmd,
  input logic [1:0]  cyc,
  input logic [7:0]  stat
);
  wire acc = req && we && !(secure_only && nonsec);
  wire clr = acc && cyc == 2'd0 && wdata[7:0] == 8'h50;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((stat & $past(stat)) == $past(stat))); // R7
  AST_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> stat == 8'h00); // R7
  AST_MODE_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cyc == 2'd0 && (wdata[7:0] == 8'h70 || wdata[7:0] == 8'h90) |=> cyc == 2'd0); // R8
  AST_PROG_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    acc && cyc == 2'd1 && (cmd == 8'h10 || cmd == 8'h40) |=> stat[7] && cyc == 2'd0); // R3
  AST_LATE_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    cmd != 8'hE8 |-> cyc < 2'd2); // R11
  AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    req && we && secure_only && nonsec |=> $stable(stat) && $stable(cyc) && $stable(cmd)); // R14
endmodule

bind nor_cmd_seq nor_cmd_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .we(we), .wdata(wdata),
  .secure_only(secure_only), .nonsec(nonsec),
  .cmd(cmd_q), .cyc(cyc_q), .stat(stat_q)
);

// File: tb/nor_cmd_seq_bench.sv
`timescale 1ns/1ps
module nor_cmd_seq_bench;
  localparam int AW = 6;
  logic clk = 0, rst_n = 0, req = 0, we = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [1:0] size = 0;
  logic big_end = 0, read_only = 0, secure_only = 0, nonsec = 0, err;
  logic last_err;
  int n_chk = 0, n_fail = 0;
  logic [7:0] mdl [64];

  always #2.5 clk = ~clk;

  nor_cmd_seq u_nor_cmd_seq (.clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr),
    .wdata(wdata), .size(size), .big_end(big_end), .read_only(read_only),
    .secure_only(secure_only), .nonsec(nonsec), .rdata(rdata), .err(err));

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [31:0] d, logic [1:0] s = 0);
    @(negedge clk);
    req = 1; we = 1; addr = AW'(a); wdata = d; size = s;
    #1 last_err = err;
    @(posedge clk);
    #1 req = 0; we = 0;
  endtask

  task automatic rd(int a, logic [1:0] s, output logic [31:0] d);
    @(negedge clk);
    req = 1; we = 0; addr = AW'(a); size = s;
    #1 d = rdata;
    req = 0;
  endtask

  function automatic int nbytes(logic [1:0] s);
    return s == 0 ? 1 : s == 1 ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_arr(int a, logic [1:0] s, logic be);
    logic [31:0] r = 0;
    int n = nbytes(s);
    for (int i = 0; i < n; i++)
      if (be) r[8*(n-1-i) +: 8] = mdl[(a+i)%64];
      else    r[8*i +: 8] = mdl[(a+i)%64];
    return r;
  endfunction

  task automatic mdl_store(int a, logic [31:0] d, logic [1:0] s, logic be);
    int n = nbytes(s);
    for (int i = 0; i < n; i++)
      mdl[(a+i)%64] = be ? d[8*(n-1-i) +: 8] : d[8*i +: 8];
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(0, 2, d); chk("R1 array after reset", d, 32'hFFFFFFFF);
    wr(0, 32'h70); rd(0, 0, d); chk("R1 status after reset", d, 32'h0);
    wr(0, 32'hFF);

    // R3 program sweep, then R2 read sweep
    for (int a = 0; a < 64; a++) begin
      wr(a, (a % 2) ? 32'h10 : 32'h40);
      wr(a, (a * 37 + 5) & 8'hFF);
      mdl[a] = 8'((a * 37 + 5) & 8'hFF);
      if (a % 16 == 3) begin rd(a, 0, d); chk("R3 status after program", d, 32'h80); end
    end
    rd(0, 1, d); chk("R3 status replicated", d, 32'h8080);
    wr(0, 32'hFF);
    for (int be = 0; be < 2; be++) begin
      big_end = 1'(be);
      for (int s = 0; s < 3; s++)
        for (int a = 0; a < 64; a++) begin
          rd(a, 2'(s), d); chk("R2 array read", d, exp_arr(a, 2'(s), 1'(be)));
        end
    end
    wr(8, 32'h10); wr(8, 32'h11223344, 2); mdl_store(8, 32'h11223344, 2, 1);
    wr(0, 32'hFF); rd(8, 2, d); chk("R3 big-endian word program", d, exp_arr(8, 2, 1));
    big_end = 0;
    rd(8, 1, d); chk("R3 little-endian view", d, exp_arr(8, 1, 0));
    wr(40, 32'h40); wr(40, 32'hCAFE, 1); mdl_store(40, 32'hCAFE, 1, 0);
    wr(0, 32'hFF); rd(40, 1, d); chk("R3 halfword program", d, 32'hCAFE);

    // R4 read-only program, R7 clear
    read_only = 1;
    wr(0, 32'h40); wr(0, 32'hAB); rd(0, 0, d); chk("R4 read-only status", d, 32'h90);
    wr(0, 32'h50); rd(0, 0, d); chk("R7 clear returns array", d, exp_arr(0, 0, 0));
    wr(0, 32'h70); rd(0, 0, d); chk("R7 status cleared", d, 32'h0);
    wr(0, 32'hFF); rd(0, 0, d); chk("R4 array unchanged", d, exp_arr(0, 0, 0));
    read_only = 0;

    // R5 R6 erase
    wr(19, 32'h20); rd(19, 0, d); chk("R5 erase status", d, 32'h80);
    for (int i = 16; i < 32; i++) mdl[i] = 8'hFF;
    wr(19, 32'hD0); rd(0, 0, d); chk("R6 confirm keeps status mode", d, 32'h80);
    wr(0, 32'hFF);
    for (int a = 14; a < 34; a++) begin rd(a, 0, d); chk("R5 sector erase", d, exp_arr(a, 0, 0)); end
    read_only = 1;
    wr(0, 32'h50); wr(37, 32'h20); rd(37, 0, d); chk("R5 read-only erase status", d, 32'hA0);
    wr(37, 32'hFF); rd(37, 0, d); chk("R6 abort to array, R5 no erase", d, exp_arr(37, 0, 0));
    read_only = 0;
    wr(0, 32'h50); wr(48, 32'h20); for (int i = 48; i < 64; i++) mdl[i] = 8'hFF;
    wr(48, 32'h55); rd(50, 0, d); chk("R6 bad confirm to array", d, 32'hFF);

    // R10 lock
    wr(0, 32'h50); wr(0, 32'h60); wr(0, 32'h01); rd(0, 0, d); chk("R10 lock 0x01", d, 32'h80);
    wr(0, 32'h50); wr(0, 32'h60); wr(0, 32'hD0); rd(0, 0, d); chk("R10 lock 0xD0", d, 32'h80);
    wr(0, 32'h50); wr(0, 32'h60); wr(0, 32'h33); rd(1, 0, d); chk("R10 bad value to array", d, exp_arr(1, 0, 0));

    // R9 identifier, R8 cycle not advanced
    wr(0, 32'h90);
    rd(0, 0, d); chk("R9 manufacturer", d, 32'h89);
    rd(1, 0, d); chk("R9 device", d, 32'h18);
    rd(2, 0, d); chk("R9 other offset", d, 32'h0);
    wr(2, 32'h40); wr(2, 32'h5A); mdl[2] = 8'h5A;
    wr(0, 32'hFF); rd(2, 0, d); chk("R8 command after 0x90", d, 32'h5A);
    wr(0, 32'h70); wr(3, 32'h10); wr(3, 32'h6C); mdl[3] = 8'h6C;
    wr(0, 32'hFF); rd(3, 0, d); chk("R8 command after 0x70", d, 32'h6C);

    // R12 query
    wr(0, 32'h98);
    rd(16, 0, d); chk("R12 query Q", d, 32'h51);
    rd(17, 0, d); chk("R12 query R", d, 32'h52);
    rd(18, 0, d); chk("R12 query Y", d, 32'h59);
    wr(0, 32'h70); rd(16, 0, d); chk("R12 stays in query", d, 32'h51);
    wr(0, 32'hFF); rd(16, 0, d); chk("R12 exit to array", d, exp_arr(16, 0, 0));

    // R11 buffered program
    wr(0, 32'h50); wr(32, 32'hE8); rd(32, 0, d); chk("R11 buffer setup status", d, 32'h80);
    wr(32, 32'h02);
    for (int k = 0; k < 3; k++) begin
      wr(32 + 2*k, 32'hA100 + 32'(k), 1); mdl_store(32 + 2*k, 32'hA100 + 32'(k), 1, 0);
    end
    wr(32, 32'hD0); rd(0, 0, d); chk("R11 confirm status", d, 32'h80);
    wr(0, 32'hFF);
    for (int k = 0; k < 4; k++) begin rd(32 + 2*k, 1, d); chk("R11 buffered words", d, exp_arr(32 + 2*k, 1, 0)); end
    wr(44, 32'hE8); wr(44, 32'h00); wr(44, 32'h3C); mdl[44] = 8'h3C;
    wr(44, 32'h77); rd(44, 0, d); chk("R11 bad confirm to array", d, 32'h3C);

    // R13 unsupported command
    wr(0, 32'h70); wr(0, 32'h33); rd(5, 0, d); chk("R13 unsupported to array", d, exp_arr(5, 0, 0));

    // R14 secure-only
    wr(0, 32'h70);
    secure_only = 1; nonsec = 1;
    rd(6, 0, d); chk("R14 non-secure read raw array", d, exp_arr(6, 0, 0));
    wr(6, 32'h40); chk("R14 err on refused write", {31'h0, last_err}, 32'h1);
    wr(6, 32'h00);
    nonsec = 0;
    rd(6, 0, d); chk("R14 mode unchanged", d, 32'h80);
    wr(0, 32'hFF); rd(6, 0, d); chk("R14 array unchanged", d, exp_arr(6, 0, 0));
    chk("R14 no err on secure write", {31'h0, last_err}, 32'h0);
    secure_only = 0;

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule